// File: doc/BRIEF.md
# Bus Address Router with Fallback Error Target

This block is the central routing point of a shared pipelined system bus. The current master drives one address bus that every target sees. The router compares the upper bits of that address against a fixed memory map with three targets: a 256 KB RAM, a 4 KB serial port window and a 4 KB timer window. It raises exactly one select line. An address that falls in none of the three windows selects a built-in fallback target. So every transfer has an owner, and the master never waits on a target that does not exist.

The select lines depend only on the address, with no register stage, so they are valid in the address phase of the transfer they belong to. When the bus is ready at a rising edge, the router records which line was high in a data-phase select register. That register steers the read data, ready and response of the owning target back to the master one phase later. The next address is decoded during the data phase of the previous transfer, so routing adds no wait cycle. The fallback target answers an active transfer with a two-cycle error response, and answers an idle or busy slot with a zero-wait okay. The full address is forwarded to the targets unchanged, so each target uses the low bits as its local offset.

Top module: `ahb_addr_router`

## Requirements
- R1: `sel_o` is a combinational function of `haddr`. It follows a change of `haddr` in the same cycle, before any clock edge.
- R2: Exactly one bit of `sel_o` is high for every value of `haddr`.
- R3: Addresses 0x0000_0000 to 0x0003_FFFF select the RAM (`sel_o[0]`). Address 0x0004_0000 does not.
- R4: Addresses 0x4000_0000 to 0x4000_0FFF select the serial port (`sel_o[1]`). Addresses 0x4000_1000 to 0x4000_1FFF select the timer (`sel_o[2]`).
- R5: Every other address selects the fallback target (`sel_o[3]`).
- R6: At a rising edge where `mst_ready` is high, the data-phase select takes the value of `sel_o`. While `mst_ready` is low, it holds. Reset sets it to the fallback target, so the return path then reads ready, okay and zero data.
- R7: `mst_rdata`, `mst_ready` and `mst_resp` come from the target named by the data-phase select. The fallback target returns zero read data.
- R8: An active transfer (htrans 2'b10 or 2'b11) accepted by the fallback target produces an error response (`mst_resp`=1) for two cycles. `mst_ready` is low in the first cycle and high in the second.
- R9: An idle (2'b00) or busy (2'b01) slot accepted by the fallback target produces one cycle with `mst_ready` high and `mst_resp`=0 (okay).
- R10: Transfers to zero-wait targets complete back to back. Each data phase follows its address phase by exactly one cycle, with `mst_ready` high.
- R11: `slv_haddr` equals `haddr` at all times, so the offset bits reach the targets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| haddr | input | AW (32) | Address from the current master |
| htrans | input | 2 | Transfer kind: 00 idle, 01 busy, 10 first, 11 continuing |
| sel_o | output | NMAP+1 (4) | One-hot select: bit0 RAM, bit1 serial port, bit2 timer, bit3 fallback |
| slv_haddr | output | AW (32) | Address forwarded to the targets |
| slv_rdata | input | NMAP*DW (96) | Read data of the mapped targets, target 0 in the low bits |
| slv_ready | input | NMAP (3) | Ready of each mapped target |
| slv_resp | input | NMAP (3) | Response of each mapped target (1 = error) |
| mst_rdata | output | DW (32) | Read data returned to the master |
| mst_ready | output | 1 | Bus ready returned to the master and to all targets |
| mst_resp | output | 1 | Response returned to the master (1 = error) |

## Verification
The bench builds the router with its default parameters: a 32-bit address, 32-bit data, an 18-bit RAM window span and 12-bit peripheral spans. With these values every window edge can be reached with one concrete address: the base, the last byte, and the first byte past the end of each window, plus far unmapped addresses. Each target returns its own distinct read data, so any wrong choice of return path is visible at the master side. A target that holds ready low exercises the hold of the data-phase select while the address moves on.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic RESP_OKAY  = 1'b0;
  localparam logic RESP_ERROR = 1'b1;

  typedef enum logic [1:0] {
    FB_IDLE     = 2'b00,
    FB_ERR_WAIT = 2'b01,
    FB_ERR_DONE = 2'b10
  } fb_state_e;

endpackage

// File: rtl/route_region_cmp.sv
module route_region_cmp #(
  parameter int AW = 32,
  parameter int NR = 3,
  parameter logic [AW-1:0] BASE [NR] = '{default: '0},
  parameter int SPAN [NR] = '{default: 12}
) (
  input  logic [AW-1:0] addr,
  output logic [NR-1:0] hit
);

  // Each window is power-of-two sized and aligned: a hit means the
  // bits above the span agree with the base.
  for (genvar r = 0; r < NR; r++) begin : g_win
    logic [AW-1:0] diff;
    assign diff   = addr ^ BASE[r];
    assign hit[r] = ((diff >> SPAN[r]) == '0);
  end

endmodule

// File: rtl/route_sel_onehot.sv
module route_sel_onehot #(
  parameter int NR = 3,
  localparam int NSEL = NR + 1
) (
  input  logic [NR-1:0]   hit,
  output logic [NSEL-1:0] sel
);

  // The lowest index wins, so the output stays one-hot even if windows
  // overlap. No hit selects the fallback slot at the top.
  logic [NR:0] taken;
  assign taken[0] = 1'b0;

  for (genvar r = 0; r < NR; r++) begin : g_pri
    assign sel[r]     = hit[r] & ~taken[r];
    assign taken[r+1] = taken[r] | hit[r];
  end

  assign sel[NSEL-1] = ~taken[NR];

endmodule

// File: rtl/route_fallback_tgt.sv
module route_fallback_tgt
  import addr_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic active,
  input  logic bus_ready,
  output logic ready_out,
  output logic resp_out
);

  fb_state_e st_q, st_d;
  logic      accept_err;

  assign accept_err = sel & active & bus_ready;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FB_IDLE:     st_d = accept_err ? FB_ERR_WAIT : FB_IDLE;
      FB_ERR_WAIT: st_d = FB_ERR_DONE;
      FB_ERR_DONE: st_d = accept_err ? FB_ERR_WAIT : FB_IDLE;
      default:     st_d = FB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FB_IDLE;
    else        st_q <= st_d;
  end

  assign ready_out = (st_q != FB_ERR_WAIT);
  assign resp_out  = (st_q == FB_IDLE) ? RESP_OKAY : RESP_ERROR;

endmodule

// File: rtl/route_dphase_mux.sv
module route_dphase_mux #(
  parameter int NSEL = 4,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSEL-1:0]   sel_in,
  input  logic              capture,
  input  logic [NSEL*DW-1:0] rdata_all,
  input  logic [NSEL-1:0]   ready_all,
  input  logic [NSEL-1:0]   resp_all,
  output logic [NSEL-1:0]   dsel,
  output logic [DW-1:0]     rdata,
  output logic              ready,
  output logic              resp
);

  localparam logic [NSEL-1:0] RST_SEL = NSEL'(1) << (NSEL - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dsel <= RST_SEL;
    else if (capture) dsel <= sel_in;
  end

  // AND-OR return path: the one-hot data-phase select gates each slot.
  logic [DW-1:0] rd_acc [NSEL+1];
  logic [NSEL:0] rdy_acc;
  logic [NSEL:0] rsp_acc;

  assign rd_acc[0]  = '0;
  assign rdy_acc[0] = 1'b0;
  assign rsp_acc[0] = 1'b0;

  for (genvar s = 0; s < NSEL; s++) begin : g_ret
    assign rd_acc[s+1]  = rd_acc[s] | (rdata_all[s*DW +: DW] & {DW{dsel[s]}});
    assign rdy_acc[s+1] = rdy_acc[s] | (ready_all[s] & dsel[s]);
    assign rsp_acc[s+1] = rsp_acc[s] | (resp_all[s] & dsel[s]);
  end

  assign rdata = rd_acc[NSEL];
  assign ready = rdy_acc[NSEL];
  assign resp  = rsp_acc[NSEL];

endmodule

// File: rtl/ahb_addr_router.sv
module ahb_addr_router
  import addr_route_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] RAM_BASE  = 32'h0000_0000,
  parameter logic [AW-1:0] UART_BASE = 32'h4000_0000,
  parameter logic [AW-1:0] TMR_BASE  = 32'h4000_1000,
  parameter int RAM_SPAN = 18,
  parameter int PER_SPAN = 12,
  localparam int NMAP = 3,
  localparam int NSEL = NMAP + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        haddr,
  input  logic [1:0]           htrans,
  output logic [NSEL-1:0]      sel_o,
  output logic [AW-1:0]        slv_haddr,
  input  logic [NMAP*DW-1:0]   slv_rdata,
  input  logic [NMAP-1:0]      slv_ready,
  input  logic [NMAP-1:0]      slv_resp,
  output logic [DW-1:0]        mst_rdata,
  output logic                 mst_ready,
  output logic                 mst_resp
);

  localparam logic [AW-1:0] WIN_BASE [NMAP] = '{RAM_BASE, UART_BASE, TMR_BASE};
  localparam int            WIN_SPAN [NMAP] = '{RAM_SPAN, PER_SPAN, PER_SPAN};

  logic [NMAP-1:0] win_hit;
  logic [NSEL-1:0] dsel_q;
  logic            fb_ready, fb_resp, xfer_active;

  assign slv_haddr   = haddr;
  assign xfer_active = (htrans == TR_NONSEQ) || (htrans == TR_SEQ);

  route_region_cmp #(.AW(AW), .NR(NMAP), .BASE(WIN_BASE), .SPAN(WIN_SPAN)) u_cmp (
    .addr (haddr),
    .hit  (win_hit)
  );

  route_sel_onehot #(.NR(NMAP)) u_sel (
    .hit (win_hit),
    .sel (sel_o)
  );

  route_fallback_tgt u_fb (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel_o[NSEL-1]),
    .active    (xfer_active),
    .bus_ready (mst_ready),
    .ready_out (fb_ready),
    .resp_out  (fb_resp)
  );

  route_dphase_mux #(.NSEL(NSEL), .DW(DW)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_in    (sel_o),
    .capture   (mst_ready),
    .rdata_all ({{DW{1'b0}}, slv_rdata}),
    .ready_all ({fb_ready, slv_ready}),
    .resp_all  ({fb_resp, slv_resp}),
    .dsel      (dsel_q),
    .rdata     (mst_rdata),
    .ready     (mst_ready),
    .resp      (mst_resp)
  );

endmodule

// File: rtl/route_checker.sv
module route_checker #(
  parameter int NSEL = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      htrans,
  input logic [NSEL-1:0] sel_o,
  input logic [NSEL-1:0] dsel,
  input logic            mst_ready,
  input logic            mst_resp
);

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_o) == 1);

  a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_ready |=> $stable(dsel));

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    mst_ready |=> dsel == $past(sel_o));

  a_r8_err_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o[NSEL-1] && htrans[1] && mst_ready) |=> (!mst_ready && mst_resp));

  a_r8_err_second: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_ready && dsel[NSEL-1]) |=> (mst_ready && mst_resp));

  a_r9_idle_okay: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o[NSEL-1] && !htrans[1] && mst_ready) |=> (mst_ready && !mst_resp));

endmodule

bind ahb_addr_router route_checker #(.NSEL(NSEL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .htrans    (htrans),
  .sel_o     (sel_o),
  .dsel      (dsel_q),
  .mst_ready (mst_ready),
  .mst_resp  (mst_resp)
);

// File: tb/sim_ahb_addr_router.sv
module sim_ahb_addr_router;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [1:0]    htrans = 2'b00;
  logic [3:0]    sel_o;
  logic [AW-1:0] slv_haddr;
  logic [3*DW-1:0] slv_rdata;
  logic [2:0]    slv_ready = 3'b111;
  logic [2:0]    slv_resp = 3'b000;
  logic [DW-1:0] mst_rdata;
  logic          mst_ready, mst_resp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  assign slv_rdata = {32'hC3C3_0002, 32'hC3C3_0001, 32'hC3C3_0000};

  always #(CLK_PERIOD/2) clk = ~clk;

  ahb_addr_router u0 (
    .clk, .rst_n, .haddr, .htrans, .sel_o, .slv_haddr,
    .slv_rdata, .slv_ready, .slv_resp, .mst_rdata, .mst_ready, .mst_resp
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_idx(input logic [31:0] a);
    if (a < 32'h0004_0000) return 0;
    if (a >= 32'h4000_0000 && a < 32'h4000_1000) return 1;
    if (a >= 32'h4000_1000 && a < 32'h4000_2000) return 2;
    return 3;
  endfunction

  function automatic logic [31:0] exp_data(input int idx);
    return (idx < 3) ? 32'hC3C3_0000 + 32'(idx) : 32'h0;
  endfunction

  task automatic t_reset_state();
    haddr = 32'hF000_0000;
    #1;
    chk(sel_o == 4'b1000, "R5 reset-time select", {28'h0, sel_o}, 32'h8);
    chk(mst_ready == 1'b1 && mst_resp == 1'b0, "R6 reset ready/okay", {30'h0, mst_ready, mst_resp}, 32'h2);
    chk(mst_rdata == 32'h0, "R6 reset points to fallback", mst_rdata, 32'h0);
  endtask

  task automatic t_boundary_sweep();
    logic [31:0] pts [11] = '{32'h0000_0000, 32'h0003_FFFF, 32'h0004_0000,
                             32'h4000_0000, 32'h4000_0FFF, 32'h4000_1000,
                             32'h4000_1FFF, 32'h4000_2000, 32'h3FFF_FFFF,
                             32'h8000_0000, 32'hFFFF_FFFF};
    for (int i = 0; i < 11; i++) begin
      int e;
      @(negedge clk);
      haddr  = pts[i];
      e      = exp_idx(pts[i]);
      htrans = (e == 3) ? 2'b00 : 2'b10;
      #1;
      chk(sel_o == 4'(1 << e), (e == 0) ? "R3 R1 RAM window" :
          (e == 3) ? "R5 R1 unmapped" : "R4 R1 peripheral window",
          {28'h0, sel_o}, 32'(1 << e));
      chk($countones(sel_o) == 1, "R2 one-hot", {28'h0, sel_o}, 32'(1 << e));
      chk(slv_haddr == pts[i], "R11 address forwarded", slv_haddr, pts[i]);
      @(posedge clk);
      #1;
      chk(mst_rdata == exp_data(e), "R7 return data follows data phase", mst_rdata, exp_data(e));
      chk(mst_ready == 1'b1, "R10 no wait added", {31'h0, mst_ready}, 32'h1);
    end
  endtask

  task automatic t_fallback_error(input logic [1:0] kind);
    @(negedge clk);
    haddr  = 32'h8000_0040;
    htrans = kind;
    @(posedge clk);
    #1;
    chk(!mst_ready && mst_resp, "R8 first error cycle", {30'h0, mst_ready, mst_resp}, 32'h1);
    @(negedge clk);
    htrans = 2'b00;
    @(posedge clk);
    #1;
    chk(mst_ready && mst_resp, "R8 second error cycle", {30'h0, mst_ready, mst_resp}, 32'h3);
    @(posedge clk);
    #1;
    chk(mst_ready && !mst_resp, "R9 idle after error", {30'h0, mst_ready, mst_resp}, 32'h2);
  endtask

  task automatic t_idle_busy();
    @(negedge clk);
    haddr  = 32'h9000_0000;
    htrans = 2'b01;
    @(posedge clk);
    #1;
    chk(mst_ready && !mst_resp, "R9 busy to fallback", {30'h0, mst_ready, mst_resp}, 32'h2);
    @(negedge clk);
    htrans = 2'b00;
    @(posedge clk);
    #1;
    chk(mst_ready && !mst_resp, "R9 idle to fallback", {30'h0, mst_ready, mst_resp}, 32'h2);
  endtask

  task automatic t_stall_hold();
    @(negedge clk);
    slv_ready = 3'b110;
    haddr  = 32'h0000_0100;
    htrans = 2'b10;
    @(posedge clk);
    #1;
    chk(mst_ready == 1'b0, "R7 wait from RAM", {31'h0, mst_ready}, 32'h0);
    @(negedge clk);
    haddr    = 32'h4000_0010;
    slv_resp = 3'b010;
    #1;
    chk(sel_o == 4'b0010, "R1 select moves during wait", {28'h0, sel_o}, 32'h2);
    @(posedge clk);
    #1;
    chk(mst_rdata == 32'hC3C3_0000 && !mst_ready, "R6 hold while waiting", mst_rdata, 32'hC3C3_0000);
    @(negedge clk);
    slv_ready = 3'b111;
    #1;
    chk(mst_ready == 1'b1, "R7 ready from RAM", {31'h0, mst_ready}, 32'h1);
    @(posedge clk);
    #1;
    chk(mst_rdata == 32'hC3C3_0001, "R6 capture after wait", mst_rdata, 32'hC3C3_0001);
    chk(mst_resp == 1'b1, "R7 response from serial port", {31'h0, mst_resp}, 32'h1);
    @(negedge clk);
    slv_resp = 3'b000;
    htrans   = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_boundary_sweep();
    t_fallback_error(2'b10);
    t_fallback_error(2'b11);
    t_idle_busy();
    t_stall_hold();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule